// File: doc/BRIEF.md
# Paravirtual Device Control Register Block

This block is the register face of a paravirtualized device toward its host driver. The driver reaches it over a simple 32-bit register bus with an address, a write strobe with data, and a read strobe that returns data in the same cycle. Through that bus the driver reads the feature word the device offers, writes back the features it accepts, and sets the queue size and the queue-ready permission. It also drives the device status byte, inspects and acknowledges interrupt causes, reads a small device-specific configuration area and reads a generation counter for that area.

On the device side, two event inputs raise the two interrupt causes: a used-ring update, and a configuration change that arrives as a byte write into the configuration area. A level interrupt line goes to the host. The generation counter lets the driver detect a torn configuration read. It advances only when the driver reads the configuration area after the device has changed it, so a read sequence that brackets the area with two generation reads can tell whether the data is consistent.

Top module: `pvdev_regfile`

## Requirements
- R1: After reset every driver-writable register, the interrupt status, the generation counter and the configuration bytes are zero, and `irq` and `queue_ready` are low.
- R2: Offset 0x00 reads the `dev_features` input with feature bit 0 in data bit 0. Offset 0x04 holds the driver-accepted feature word, is read/write, and drives `drv_features`.
- R3: Offset 0x08 holds the queue size, which applies to the descriptor table and to both rings. It keeps the low QSIZE_W (16) bits of a write, reads the upper bits as zero, and drives `queue_size`.
- R4: Bit 0 of offset 0x0C is queue-ready. Writing 1 sets it and writing 0 clears it, and `queue_ready` follows it one cycle after the write.
- R5: An access whose address bits [1:0] are not zero, or whose address is unmapped, changes no register on a write and returns zero on a read. Reads of the write-only acknowledge offset 0x18 also return zero.
- R6: Offset 0x14 is the read-only interrupt status. Bit 0 is set by `ring_evt` and bit 1 by `cfg_wr_en`, in the cycle after the event. `irq` is high exactly when either bit is set.
- R7: A write to offset 0x18 clears only the status bits written as 1. A 1 for a cause that is not pending changes nothing. A device event in the same cycle as the acknowledge of its bit leaves the bit set.
- R8: The configuration area starts at offset 0x20 and spans CFG_WORDS words. It reads little-endian: byte index i lies in word i/4, bits 8*(i%4)+7 down to 8*(i%4). `cfg_wr_idx`/`cfg_wr_data` write one byte per cycle while `cfg_wr_en` is high.
- R9: Offset 0x1C reads the generation counter. It increases by exactly one, modulo 2^32, on a driver read of the configuration area made after at least one device configuration write since the previous such read. Any other read leaves it unchanged, including repeated device writes before a single read.
- R10: Offset 0x10 holds the 8-bit device status and drives `dev_status`. Writing 0 also clears the driver-accepted features, queue-ready and both interrupt status bits.
- R11: While status bit 7 (failed) is set, writes to offsets 0x04, 0x08 and 0x0C are ignored. A write of 0 to the status register lifts the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd` |
| dev_features | input | 32 | Feature word offered by the device |
| ring_evt | input | 1 | Used-ring update cause |
| cfg_wr_en | input | 1 | Device writes one configuration byte |
| cfg_wr_idx | input | clog2(4*CFG_WORDS) | Configuration byte index |
| cfg_wr_data | input | 8 | Configuration byte value |
| drv_features | output | 32 | Features accepted by the driver |
| queue_size | output | QSIZE_W | Queue element count |
| queue_ready | output | 1 | Device may execute queue requests |
| dev_status | output | 8 | Device status byte |
| irq | output | 1 | Level interrupt to the host |

## Verification
The assertions check several rules on every cycle. Each device event sets its status bit in the next cycle. An acknowledge that leaves a bit as 0 spares a pending cause. Misaligned writes leave all state untouched. The lock holds while the failed bit is set. The generation counter moves only one step, and only after a read of changed configuration data. Only the bench's scenarios can show the end-to-end values: little-endian byte placement in the configuration words, the generation count across repeated device writes and repeated driver reads, the clear-on-zero-status effects seen through read-back, and the zero returned for misaligned, unmapped and write-only addresses.

// File: rtl/pvdev_pkg.sv
package pvdev_pkg;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_DEVF,
        SEL_DRVF,
        SEL_QSIZE,
        SEL_QRDY,
        SEL_STAT,
        SEL_ISR,
        SEL_IACK,
        SEL_GEN,
        SEL_CFG
    } sel_e;

    localparam int OFF_DEVF  = 'h00;
    localparam int OFF_DRVF  = 'h04;
    localparam int OFF_QSIZE = 'h08;
    localparam int OFF_QRDY  = 'h0C;
    localparam int OFF_STAT  = 'h10;
    localparam int OFF_ISR   = 'h14;
    localparam int OFF_IACK  = 'h18;
    localparam int OFF_GEN   = 'h1C;
    localparam int OFF_CFG   = 'h20;

    localparam int FAILED_BIT = 7;
    localparam int ISR_RING   = 0;
    localparam int ISR_CFG    = 1;

endpackage

// File: rtl/pvdev_decode.sv
module pvdev_decode #(
    parameter int ADDR_W    = 8,
    parameter int CFG_WORDS = 2,
    parameter int CFG_IDX_W = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1
) (
    input  logic [ADDR_W-1:0]    addr,
    output pvdev_pkg::sel_e      sel,
    output logic [CFG_IDX_W-1:0] cfg_word
);
    import pvdev_pkg::*;

    localparam int CFG_END = OFF_CFG + 4 * CFG_WORDS;

    int  a_int;
    logic aligned;

    always_comb begin
        a_int    = int'(addr);
        aligned  = (addr[1:0] == 2'b00);
        sel      = SEL_NONE;
        cfg_word = CFG_IDX_W'((a_int - OFF_CFG) >>> 2);
        if (aligned) begin
            if      (a_int == OFF_DEVF)  sel = SEL_DEVF;
            else if (a_int == OFF_DRVF)  sel = SEL_DRVF;
            else if (a_int == OFF_QSIZE) sel = SEL_QSIZE;
            else if (a_int == OFF_QRDY)  sel = SEL_QRDY;
            else if (a_int == OFF_STAT)  sel = SEL_STAT;
            else if (a_int == OFF_ISR)   sel = SEL_ISR;
            else if (a_int == OFF_IACK)  sel = SEL_IACK;
            else if (a_int == OFF_GEN)   sel = SEL_GEN;
            else if (a_int >= OFF_CFG && a_int < CFG_END) sel = SEL_CFG;
        end
    end

endmodule

// File: rtl/pvdev_cfg_track.sv
module pvdev_cfg_track #(
    parameter int CFG_WORDS  = 2,
    parameter int CFG_IDX_W  = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1,
    parameter int BYTE_IDX_W = $clog2(CFG_WORDS * 4)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dev_wr,
    input  logic [BYTE_IDX_W-1:0] dev_idx,
    input  logic [7:0]            dev_data,
    input  logic                  drv_rd,
    input  logic [CFG_IDX_W-1:0]  rd_word,
    output logic [31:0]           rd_data,
    output logic [31:0]           gen
);
    localparam int CFG_BYTES = CFG_WORDS * 4;
    localparam int CFG_BITS  = CFG_BYTES * 8;

    typedef struct packed {
        logic [CFG_BITS-1:0] bytes;
        logic                dirty;
        logic [31:0]         gen;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (drv_rd) begin
            st_d.dirty = 1'b0;
            if (st_q.dirty) st_d.gen = st_q.gen + 32'd1;
        end
        if (dev_wr) begin
            st_d.dirty = 1'b1;
            if (int'(dev_idx) < CFG_BYTES)
                st_d.bytes[dev_idx*8 +: 8] = dev_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.bytes[rd_word*32 +: 32];
    assign gen     = st_q.gen;

    assert_gen_needs_dirty_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.gen != $past(st_q.gen)) |-> $past(drv_rd && st_q.dirty));

    assert_gen_single_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_rd && st_q.dirty) |=> (st_q.gen == $past(st_q.gen) + 32'd1));

    assert_dev_write_marks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dev_wr |=> st_q.dirty);

endmodule

// File: rtl/pvdev_regfile.sv
module pvdev_regfile #(
    parameter int ADDR_W    = 8,
    parameter int QSIZE_W   = 16,
    parameter int CFG_WORDS = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   bus_addr,
    input  logic                                bus_wr,
    input  logic [31:0]                         bus_wdata,
    input  logic                                bus_rd,
    output logic [31:0]                         bus_rdata,
    input  logic [31:0]                         dev_features,
    input  logic                                ring_evt,
    input  logic                                cfg_wr_en,
    input  logic [$clog2(CFG_WORDS*4)-1:0]      cfg_wr_idx,
    input  logic [7:0]                          cfg_wr_data,
    output logic [31:0]                         drv_features,
    output logic [QSIZE_W-1:0]                  queue_size,
    output logic                                queue_ready,
    output logic [7:0]                          dev_status,
    output logic                                irq
);
    import pvdev_pkg::*;

    localparam int CFG_IDX_W  = (CFG_WORDS > 1) ? $clog2(CFG_WORDS) : 1;
    localparam int BYTE_IDX_W = $clog2(CFG_WORDS * 4);

    typedef struct packed {
        logic [31:0]        drvf;
        logic [QSIZE_W-1:0] qsize;
        logic               qrdy;
        logic [7:0]         status;
        logic [1:0]         isr;
    } reg_state_t;

    reg_state_t st_d, st_q;

    sel_e                 sel;
    logic [CFG_IDX_W-1:0] cfg_word;
    logic [31:0]          cfg_rdata;
    logic [31:0]          gen_val;
    logic                 cfg_rd;
    logic                 locked;

    pvdev_decode #(
        .ADDR_W    (ADDR_W),
        .CFG_WORDS (CFG_WORDS),
        .CFG_IDX_W (CFG_IDX_W)
    ) u_decode (
        .addr     (bus_addr),
        .sel      (sel),
        .cfg_word (cfg_word)
    );

    assign cfg_rd = bus_rd && (sel == SEL_CFG);

    pvdev_cfg_track #(
        .CFG_WORDS  (CFG_WORDS),
        .CFG_IDX_W  (CFG_IDX_W),
        .BYTE_IDX_W (BYTE_IDX_W)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_wr   (cfg_wr_en),
        .dev_idx  (cfg_wr_idx),
        .dev_data (cfg_wr_data),
        .drv_rd   (cfg_rd),
        .rd_word  (cfg_word),
        .rd_data  (cfg_rdata),
        .gen      (gen_val)
    );

    always_comb begin
        st_d   = st_q;
        locked = st_q.status[FAILED_BIT];
        if (bus_wr) begin
            case (sel)
                SEL_DRVF:  if (!locked) st_d.drvf  = bus_wdata;
                SEL_QSIZE: if (!locked) st_d.qsize = bus_wdata[QSIZE_W-1:0];
                SEL_QRDY:  if (!locked) st_d.qrdy  = bus_wdata[0];
                SEL_STAT: begin
                    st_d.status = bus_wdata[7:0];
                    if (bus_wdata[7:0] == 8'h00) begin
                        st_d.drvf = '0;
                        st_d.qrdy = 1'b0;
                        st_d.isr  = '0;
                    end
                end
                SEL_IACK:  st_d.isr = st_q.isr & ~bus_wdata[1:0];
                default: ;
            endcase
        end
        st_d.isr[ISR_RING] = st_d.isr[ISR_RING] | ring_evt;
        st_d.isr[ISR_CFG]  = st_d.isr[ISR_CFG]  | cfg_wr_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (sel)
                SEL_DEVF:  bus_rdata = dev_features;
                SEL_DRVF:  bus_rdata = st_q.drvf;
                SEL_QSIZE: bus_rdata = 32'(st_q.qsize);
                SEL_QRDY:  bus_rdata = {31'b0, st_q.qrdy};
                SEL_STAT:  bus_rdata = {24'b0, st_q.status};
                SEL_ISR:   bus_rdata = {30'b0, st_q.isr};
                SEL_GEN:   bus_rdata = gen_val;
                SEL_CFG:   bus_rdata = cfg_rdata;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign drv_features = st_q.drvf;
    assign queue_size   = st_q.qsize;
    assign queue_ready  = st_q.qrdy;
    assign dev_status   = st_q.status;
    assign irq          = |st_q.isr;

    assert_ring_sets_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ring_evt |=> (irq && bus_rdata_isr_bit0()));

    assert_ack_spares_zero_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_IACK && !bus_wdata[ISR_CFG] && st_q.isr[ISR_CFG]) |=> st_q.isr[ISR_CFG]);

    assert_event_beats_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_en && bus_wr && sel == SEL_IACK) |=> irq);

    assert_misaligned_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] != 2'b00 && !ring_evt && !cfg_wr_en) |=> $stable(st_q));

    assert_ready_follows_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_QRDY && !dev_status[FAILED_BIT]) |=> (queue_ready == $past(bus_wdata[0])));

    assert_failed_locks_features_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_status[FAILED_BIT] && bus_wr && sel == SEL_DRVF) |=> $stable(drv_features));

    assert_zero_status_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == SEL_STAT && bus_wdata[7:0] == 8'h00) |=> (!queue_ready && drv_features == 32'h0));

    function automatic logic bus_rdata_isr_bit0();
        return st_q.isr[ISR_RING];
    endfunction

endmodule

// File: tb/sim_pvdev_regfile.sv
module sim_pvdev_regfile;

    localparam logic [31:0] DEVF = 32'hA5C3_0F01;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        ring_evt = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [2:0]  cfg_wr_idx = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [31:0] drv_features;
    logic [15:0] queue_size;
    logic        queue_ready;
    logic [7:0]  dev_status;
    logic        irq;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pvdev_regfile u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_addr     (bus_addr),
        .bus_wr       (bus_wr),
        .bus_wdata    (bus_wdata),
        .bus_rd       (bus_rd),
        .bus_rdata    (bus_rdata),
        .dev_features (DEVF),
        .ring_evt     (ring_evt),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_idx   (cfg_wr_idx),
        .cfg_wr_data  (cfg_wr_data),
        .drv_features (drv_features),
        .queue_size   (queue_size),
        .queue_ready  (queue_ready),
        .dev_status   (dev_status),
        .irq          (irq)
    );

    typedef struct packed {
        logic        is_wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 32'h0,         DEVF,          8'd2},
        '{1'b1, 8'h04, 32'h0000_0003, 32'h0,         8'd2},
        '{1'b0, 8'h04, 32'h0,         32'h0000_0003, 8'd2},
        '{1'b1, 8'h08, 32'hFFFF_0100, 32'h0,         8'd3},
        '{1'b0, 8'h08, 32'h0,         32'h0000_0100, 8'd3},
        '{1'b1, 8'h0C, 32'h0000_0001, 32'h0,         8'd4},
        '{1'b0, 8'h0C, 32'h0,         32'h0000_0001, 8'd4},
        '{1'b1, 8'h06, 32'hFFFF_FFFF, 32'h0,         8'd5},
        '{1'b0, 8'h04, 32'h0,         32'h0000_0003, 8'd5},
        '{1'b0, 8'h05, 32'h0,         32'h0,         8'd5},
        '{1'b1, 8'h3C, 32'h0000_1234, 32'h0,         8'd5},
        '{1'b0, 8'h3C, 32'h0,         32'h0,         8'd5},
        '{1'b0, 8'h18, 32'h0,         32'h0,         8'd5},
        '{1'b1, 8'h0C, 32'h0,         32'h0,         8'd4},
        '{1'b0, 8'h0C, 32'h0,         32'h0,         8'd4},
        '{1'b1, 8'h10, 32'h0000_000F, 32'h0,         8'd10},
        '{1'b0, 8'h10, 32'h0,         32'h0000_000F, 8'd10},
        '{1'b0, 8'h14, 32'h0,         32'h0,         8'd6},
        '{1'b0, 8'h1C, 32'h0,         32'h0,         8'd9}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_check(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(req, v, exp);
    endtask

    task automatic dev_cfg(input logic [2:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_idx = idx; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic ring_pulse();
        @(negedge clk);
        ring_evt = 1'b1;
        @(negedge clk);
        ring_evt = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq", 32'(irq), 32'h0);
        check("R1 queue_ready", 32'(queue_ready), 32'h0);
        check("R1 drv_features", drv_features, 32'h0);
        check("R1 queue_size", 32'(queue_size), 32'h0);
        check("R1 dev_status", 32'(dev_status), 32'h0);
        read_check("R1 gen", 8'h1C, 32'h0);
        read_check("R1 cfg", 8'h20, 32'h0);

        // table of bus vectors
        for (int i = 0; i < NV; i++) begin
            if (VEC[i].is_wr) begin
                bus_write(VEC[i].addr, VEC[i].data);
            end else begin
                read_check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].addr, VEC[i].exp);
            end
        end
        check("R3 queue_size port", 32'(queue_size), 32'h0000_0100);
        check("R2 drv_features port", drv_features, 32'h0000_0003);

        // R4: port follows register
        bus_write(8'h0C, 32'h1);
        check("R4 queue_ready set", 32'(queue_ready), 32'h1);
        bus_write(8'h0C, 32'h0);
        check("R4 queue_ready clear", 32'(queue_ready), 32'h0);

        // R6/R8: device causes
        ring_pulse();
        check("R6 irq on ring", 32'(irq), 32'h1);
        read_check("R6 isr ring", 8'h14, 32'h1);
        dev_cfg(3'd0, 8'h11);
        dev_cfg(3'd5, 8'h66);
        read_check("R6 isr both", 8'h14, 32'h3);

        // R7: selective acknowledge
        bus_write(8'h18, 32'h1);
        read_check("R7 ack ring only", 8'h14, 32'h2);
        check("R7 irq still high", 32'(irq), 32'h1);
        bus_write(8'h18, 32'h1);
        read_check("R7 ack not pending", 8'h14, 32'h2);
        bus_write(8'h18, 32'h2);
        read_check("R7 ack cfg", 8'h14, 32'h0);
        check("R6 irq low", 32'(irq), 32'h0);
        @(negedge clk);
        bus_addr = 8'h18; bus_wdata = 32'h1; bus_wr = 1'b1; ring_evt = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ring_evt = 1'b0;
        read_check("R7 event beats ack", 8'h14, 32'h1);
        bus_write(8'h18, 32'h3);

        // R9/R8: generation and byte layout
        read_check("R9 gen before read", 8'h1C, 32'h0);
        read_check("R8 cfg word0", 8'h20, 32'h0000_0011);
        read_check("R9 gen after dirty read", 8'h1C, 32'h1);
        read_check("R8 cfg word1", 8'h24, 32'h0000_6600);
        read_check("R9 gen clean read", 8'h1C, 32'h1);
        dev_cfg(3'd7, 8'hAB);
        dev_cfg(3'd2, 8'h5C);
        read_check("R9 gen no read yet", 8'h1C, 32'h1);
        read_check("R8 cfg word1 b7", 8'h24, 32'hAB00_6600);
        read_check("R9 gen one step", 8'h1C, 32'h2);
        read_check("R8 cfg word0 b2", 8'h20, 32'h005C_0011);
        read_check("R9 gen steady", 8'h1C, 32'h2);

        // R10: zero status clears
        bus_write(8'h04, 32'hDEAD_0001);
        bus_write(8'h0C, 32'h1);
        ring_pulse();
        bus_write(8'h10, 32'h0);
        read_check("R10 drv feat cleared", 8'h04, 32'h0);
        check("R10 queue_ready cleared", 32'(queue_ready), 32'h0);
        read_check("R10 isr cleared", 8'h14, 32'h0);
        check("R10 irq cleared", 32'(irq), 32'h0);

        // R11: failed lock
        bus_write(8'h10, 32'h80);
        check("R11 status port", 32'(dev_status), 32'h80);
        bus_write(8'h04, 32'h5);
        read_check("R11 drv feat locked", 8'h04, 32'h0);
        bus_write(8'h0C, 32'h1);
        check("R11 ready locked", 32'(queue_ready), 32'h0);
        bus_write(8'h08, 32'h40);
        read_check("R11 qsize locked", 8'h08, 32'h0000_0100);
        bus_write(8'h10, 32'h0);
        bus_write(8'h0C, 32'h1);
        check("R11 unlocked", 32'(queue_ready), 32'h1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule